// File: doc/BRIEF.md
# Multicast Request Reservation Arbiter

This block is the switch-side part that turns repeated connection requests from several input ports into reservations on output ports. In any cycle, each input may present a request: a valid strobe plus a bitmap naming the outputs it wants. A request is looked at only in the cycle it arrives and is then forgotten. Each wanted output that is free in that cycle is reserved for the requester. An input that keeps repeating its request gathers more of its outputs over time. When an input holds every output in its bitmap, it receives a one-cycle acknowledge.

An output is free when no input holds it and its external busy line is low. When several inputs want the same free output in the same cycle, a round-robin pointer kept per output chooses the winner. A reservation stays until the owning input raises its release line. An input that repeats its request more often gets more chances at a contested output.

Top module: `mcast_resv_arbiter`

## Requirements
- R1: A valid request with a nonzero bitmap reserves every wanted output that is free in that cycle. The reservation is visible on `resv_map` after the next rising edge. Bit `i*N_OUT+o` of `resv_map` is set when input `i` owns output `o`. `req_map` uses the same layout.
- R2: Requests are not stored. An output that a request could not get stays unreserved in later cycles unless the request is presented again.
- R3: Reservations of an input accumulate across repeated requests. An owned output stays owned until that input is released.
- R4: `ack[i]` is high for exactly the cycle after a valid request from input `i` for which, after that cycle's update, input `i` owns every output in its bitmap. A repeated request that finds the full set already owned acknowledges again.
- R5: An output owned by one input is never given to another until the owner is released, so each output has at most one owner.
- R6: An output whose `out_busy` bit is high in a cycle is not reserved in that cycle.
- R7: Among inputs contending for a free output, the first at or after that output's pointer (counting upward and wrapping) wins. The pointer then moves to the input after the winner. Every pointer is 0 after reset.
- R8: `rel_in[i]` clears all of input `i`'s reservations at the next edge. It overrides a request from the same input in that cycle. The freed outputs become available to requests in the following cycle.
- R9: A valid request whose bitmap is all zeros has no effect and yields no acknowledge.
- R10: During and right after reset, `ack` and `resv_map` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_IN | Per-input request strobe |
| req_map | input | N_IN*N_OUT | Per-input wanted-output bitmap, row `i` at bits `i*N_OUT +: N_OUT` |
| rel_in | input | N_IN | Per-input release of all reservations |
| out_busy | input | N_OUT | External busy indication per output |
| ack | output | N_IN | One-cycle acknowledge per input |
| resv_map | output | N_IN*N_OUT | Current ownership matrix, same layout as `req_map` |

## Verification
The bench builds the arbiter with three inputs and four outputs. Three is the smallest input count where the round-robin search has to skip a non-requesting input and also wrap past the top index, so each pointer's full path can be followed by hand. Four outputs leave room for a two-output multicast, a busy output and a separately contested output at the same time. With only twelve matrix bits, every expected ownership state is written as a literal after each step.

// File: rtl/mra_pkg.sv
package mra_pkg;

    // Upper bound accepted for either port count.
    parameter int unsigned MAX_PORTS = 32;

    // Index arithmetic modulo the port count, used by the round-robin search.
    function automatic int unsigned wrap_add(int unsigned base,
                                             int unsigned step,
                                             int unsigned n);
        int unsigned s;
        s = base + step;
        while (s >= n) s = s - n;
        return s;
    endfunction

    // Outputs still missing for one input after an update.
    function automatic logic any_missing(logic [MAX_PORTS-1:0] want,
                                         logic [MAX_PORTS-1:0] have);
        return |(want & ~have);
    endfunction

endpackage

// File: rtl/mra_out_slice.sv
module mra_out_slice
    import mra_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req_col,   // filtered requests for this output
    input  logic [N_IN-1:0] rel,       // per-input release
    input  logic            ext_busy,
    output logic [N_IN-1:0] grant,     // winner this cycle (one-hot or zero)
    output logic [N_IN-1:0] owner      // registered owner (one-hot or zero)
);

    localparam int PTR_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    typedef struct packed {
        logic [N_IN-1:0]  owner;
        logic [PTR_W-1:0] ptr;
    } slice_state_t;

    slice_state_t st_q, st_d;
    logic         free_now;
    logic         found;
    logic [PTR_W-1:0] win_idx;
    int unsigned  idx;

    assign free_now = (st_q.owner == '0) && !ext_busy;

    always_comb begin
        grant   = '0;
        found   = 1'b0;
        win_idx = '0;
        idx     = 0;
        for (int k = 0; k < N_IN; k++) begin
            idx = wrap_add(int'(st_q.ptr), k, N_IN);
            if (!found && free_now && req_col[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
                win_idx    = PTR_W'(idx);
            end
        end
    end

    always_comb begin
        st_d.owner = (st_q.owner & ~rel) | grant;
        st_d.ptr   = st_q.ptr;
        if (found) st_d.ptr = PTR_W'(wrap_add(int'(win_idx), 1, N_IN));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign owner = st_q.owner;

endmodule

// File: rtl/mra_ack_unit.sv
module mra_ack_unit
    import mra_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,   // valid, nonzero, not released
    input  logic [N_OUT-1:0] want,
    input  logic [N_OUT-1:0] held,
    input  logic [N_OUT-1:0] won,
    output logic             ack
);

    logic [MAX_PORTS-1:0] want_w, have_w;
    logic                 ack_d;

    always_comb begin
        want_w             = '0;
        have_w             = '0;
        want_w[N_OUT-1:0]  = want;
        have_w[N_OUT-1:0]  = held | won;
        ack_d              = live && !any_missing(want_w, have_w);
    end

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= ack_d;
    end

endmodule

// File: rtl/mcast_resv_arbiter.sv
module mcast_resv_arbiter
    import mra_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IN-1:0]         req_valid,
    input  logic [N_IN*N_OUT-1:0]   req_map,
    input  logic [N_IN-1:0]         rel_in,
    input  logic [N_OUT-1:0]        out_busy,
    output logic [N_IN-1:0]         ack,
    output logic [N_IN*N_OUT-1:0]   resv_map
);

    logic [N_IN-1:0]             live;
    logic [N_OUT-1:0][N_IN-1:0]  req_c, grant_c, own_c;
    logic [N_IN-1:0][N_OUT-1:0]  want_r, grant_r, own_r;

    // Request filtering and row/column reshaping.
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign want_r[i] = req_map[i*N_OUT +: N_OUT];
        assign live[i]   = req_valid[i] && !rel_in[i] && (want_r[i] != '0);
        for (genvar o = 0; o < N_OUT; o++) begin : g_x
            assign req_c[o][i]            = live[i] && want_r[i][o];
            assign grant_r[i][o]          = grant_c[o][i];
            assign own_r[i][o]            = own_c[o][i];
            assign resv_map[i*N_OUT + o]  = own_c[o][i];
        end

        mra_ack_unit #(.N_OUT(N_OUT)) u_ack (
            .clk  (clk),
            .rst  (rst),
            .live (live[i]),
            .want (want_r[i]),
            .held (own_r[i]),
            .won  (grant_r[i]),
            .ack  (ack[i])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        mra_out_slice #(.N_IN(N_IN)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .req_col  (req_c[o]),
            .rel      (rel_in),
            .ext_busy (out_busy[o]),
            .grant    (grant_c[o]),
            .owner    (own_c[o])
        );
    end

endmodule

// File: rtl/mra_checker.sv
module mra_checker #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_IN-1:0]       req_valid,
    input logic [N_IN*N_OUT-1:0] req_map,
    input logic [N_IN-1:0]       rel_in,
    input logic [N_OUT-1:0]      out_busy,
    input logic [N_IN-1:0]       ack,
    input logic [N_IN*N_OUT-1:0] resv_map
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        logic [N_IN-1:0] col;
        for (genvar i = 0; i < N_IN; i++) begin : g_c
            assign col[i] = resv_map[i*N_OUT + o];
        end

        // R5: never two owners of one output
        a_r5_single_owner: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));

        // R6: an unowned busy output stays unowned
        a_r6_busy_not_taken: assert property (@(posedge clk) disable iff (rst)
            (col == '0) && out_busy[o] |=> (col == '0));
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_row
        // R4: acknowledge only with the full requested set owned
        a_r4_ack_full: assert property (@(posedge clk) disable iff (rst)
            ack[i] |-> (($past(req_map[i*N_OUT +: N_OUT])
                         & ~resv_map[i*N_OUT +: N_OUT]) == '0));

        // R4: acknowledge follows a request
        a_r4_ack_after_req: assert property (@(posedge clk) disable iff (rst)
            ack[i] |-> $past(req_valid[i]));

        // R8: release empties the row
        a_r8_release_clears: assert property (@(posedge clk) disable iff (rst)
            rel_in[i] |=> (resv_map[i*N_OUT +: N_OUT] == '0));

        // R9: empty bitmap gives no acknowledge
        a_r9_zero_no_ack: assert property (@(posedge clk) disable iff (rst)
            req_valid[i] && (req_map[i*N_OUT +: N_OUT] == '0) |=> !ack[i]);

        for (genvar o = 0; o < N_OUT; o++) begin : g_b
            // R3: ownership persists until release
            a_r3_keep: assert property (@(posedge clk) disable iff (rst)
                resv_map[i*N_OUT + o] && !rel_in[i] |=> resv_map[i*N_OUT + o]);
        end
    end

endmodule

bind mcast_resv_arbiter mra_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/test_mcast_resv_arbiter.sv
`timescale 1ns/1ps
module test_mcast_resv_arbiter;

    localparam int NI = 3;
    localparam int NO = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NI-1:0]    req_valid = '0;
    logic [NI*NO-1:0] req_map = '0;
    logic [NI-1:0]    rel_in = '0;
    logic [NO-1:0]    out_busy = '0;
    logic [NI-1:0]    ack;
    logic [NI*NO-1:0] resv_map;

    always #2.5 clk = ~clk;   // 200 MHz

    mcast_resv_arbiter #(.N_IN(NI), .N_OUT(NO)) i_mcast_resv_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_map(req_map),
        .rel_in(rel_in), .out_busy(out_busy), .ack(ack), .resv_map(resv_map)
    );

    typedef struct {
        logic [NI-1:0]    e_ack;
        logic [NI*NO-1:0] e_map;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic step(input logic [NI-1:0] v, input logic [NI*NO-1:0] m,
                        input logic [NI-1:0] r, input logic [NO-1:0] b,
                        input logic [NI-1:0] ea, input logic [NI*NO-1:0] em,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_map = m; rel_in = r; out_busy = b;
        e.e_ack = ea; e.e_map = em; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one expected item per clock, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (ack !== e.e_ack) begin
                    n_fail++;
                    $display("FAIL %s ack got %b exp %b", e.tag, ack, e.e_ack);
                end
                n_run++;
                if (resv_map !== e.e_map) begin
                    n_fail++;
                    $display("FAIL %s resv_map got %h exp %h", e.tag, resv_map, e.e_map);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired, got running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(3'b000, 12'h000, 3'b000, 4'b0000, 3'b000, 12'h000, "R10 reset state");
        step(3'b001, 12'h003, 3'b000, 4'b0000, 3'b001, 12'h003, "R1 R4 unicast pair");
        step(3'b000, 12'h000, 3'b001, 4'b0000, 3'b000, 12'h000, "R8 release");
        step(3'b010, 12'h060, 3'b000, 4'b0100, 3'b000, 12'h020, "R6 busy output skipped");
        step(3'b000, 12'h000, 3'b000, 4'b0000, 3'b000, 12'h020, "R2 request not stored");
        step(3'b010, 12'h060, 3'b000, 4'b0000, 3'b010, 12'h060, "R3 accumulate");
        step(3'b101, 12'h002, 3'b000, 4'b0000, 3'b000, 12'h060, "R5 R9 held and empty");
        step(3'b000, 12'h000, 3'b010, 4'b0000, 3'b000, 12'h000, "R8 release");
        step(3'b101, 12'h808, 3'b000, 4'b0000, 3'b001, 12'h008, "R7 pointer at zero");
        step(3'b000, 12'h000, 3'b001, 4'b0000, 3'b000, 12'h000, "R8 release");
        step(3'b101, 12'h808, 3'b000, 4'b0000, 3'b100, 12'h800, "R7 rotation skip");
        step(3'b101, 12'h808, 3'b100, 4'b0000, 3'b000, 12'h000, "R8 release overrides");
        step(3'b001, 12'h008, 3'b000, 4'b0000, 3'b001, 12'h008, "R8 R7 freed and wrapped");
        step(3'b001, 12'h008, 3'b000, 4'b0000, 3'b001, 12'h008, "R4 repeat ack");
        step(3'b000, 12'h000, 3'b001, 4'b0000, 3'b000, 12'h000, "R8 release");
        step(3'b011, 12'h033, 3'b000, 4'b0000, 3'b000, 12'h012, "R7 R3 split multicast");
        step(3'b000, 12'h000, 3'b000, 4'b0000, 3'b000, 12'h012, "R4 single pulse");
        step(3'b001, 12'h003, 3'b010, 4'b0000, 3'b000, 12'h002, "R8 not free in release cycle");
        step(3'b001, 12'h003, 3'b000, 4'b0000, 3'b001, 12'h003, "R3 complete after repeat");
        step(3'b000, 12'h000, 3'b000, 4'b0000, 3'b000, 12'h003, "R4 pulse ends");
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule